// File: doc/BRIEF.md
# Floating-Point Subtract Special-Case Resolver

This block sits at the front of a double-precision subtract pipeline. It receives the two operands x and y after classification: each has a class code, a sign bit and its raw 64-bit encoding. It decides whether the difference x minus y can be settled without any mantissa arithmetic. When it can, the block delivers the final 64-bit result and the invalid-operation flag. When it cannot, it raises a proceed signal and marks which of the two operands are denormal and must be pre-normalized by the arithmetic stage that follows.

Any operation that involves a NaN is resolved by one fixed precedence. A signalling x comes first, then a signalling y, then a quiet x, then a quiet y. The class pairs made of infinities and zeros are then resolved in the usual way. The sign of an exact zero produced by subtracting two zeros of the same sign follows the rounding mode. The decision and its outputs are registered, so they appear one clock after the operands are presented.

Top module: `fpsub_resolver`

## Requirements
- R1: Class codes are 3 bits: 0 zero, 1 normal, 2 denormal, 3 infinity, 4 quiet NaN, 5 signalling NaN. Codes 6 and 7 are handled as normal. The outputs for an operation presented with `in_valid` high appear one clock later with `out_valid` high. Synchronous reset clears every output to zero.
- R2: If x is a signalling NaN, the result is x_raw with fraction bit 51 set, and invalid is 1. This holds for every class of y, including a signalling y.
- R3: If y is a signalling NaN and x is not, the result is y_raw with fraction bit 51 set, and invalid is 1. This holds even when x is a quiet NaN.
- R4: If y is a quiet NaN and x is zero, normal, denormal or infinity, the result is y_raw unchanged.
- R5: If x is a quiet NaN and y is not a signalling NaN, the result is x_raw unchanged.
- R6: Infinity minus infinity with different sign inputs returns x_raw. With equal signs it returns 0x7FF8000000000000 and sets invalid.
- R7: Zero, normal or denormal x minus an infinite y returns an infinity whose sign is the inverse of y_sign (exponent all ones, fraction zero).
- R8: Infinite x minus a zero, normal or denormal y returns x_raw.
- R9: Zero minus zero with different signs returns x_raw. With equal signs the result is zero, and its sign bit is 1 only when round_mode is 3 (toward minus infinity; 0 nearest, 1 toward zero, 2 toward plus infinity).
- R10: A normal or denormal x minus a zero y returns x_raw. A zero x minus a normal or denormal y returns y_raw with bit 63 inverted.
- R11: When both operands are normal or denormal, proceed is 1, settled is 0 and result is 0, and norm_x and norm_y mark the denormal operands. Otherwise settled is 1 and proceed, norm_x and norm_y are 0.
- R12: Invalid is set only in the cases named in R2, R3 and R6. It is cleared for every other operation, so nothing carries over from an earlier one.
- R13: A cycle after `in_valid` is low has out_valid, settled, proceed, invalid, norm_x and norm_y at 0 and result at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| x_cls | input | 3 | Class code of x |
| x_sign | input | 1 | Sign of x |
| x_raw | input | 64 | Encoding of x |
| y_cls | input | 3 | Class code of y |
| y_sign | input | 1 | Sign of y |
| y_raw | input | 64 | Encoding of y |
| round_mode | input | 2 | Rounding mode code |
| out_valid | output | 1 | Outputs valid |
| out_settled | output | 1 | Result is final |
| out_proceed | output | 1 | Arithmetic path needed |
| out_result | output | 64 | Final result when settled |
| out_invalid | output | 1 | Invalid-operation flag |
| out_norm_x | output | 1 | x must be pre-normalized |
| out_norm_y | output | 1 | y must be pre-normalized |

## Verification
The bench sweeps every class pair against both signs of each operand and all four rounding modes, and it varies the payloads. The NaN precedence corners matter most. A design that let a quiet x win over a signalling y would return an unquieted NaN without the flag. A design that treated a signalling y before a signalling x would pick the wrong payload. The bench also covers equal-sign zero minus zero under each rounding mode, where a wrong design gives a negative zero outside the downward mode. It covers infinity minus infinity, where swapping the sign test gives invalid for opposite signs, and zero minus a finite value, where a missing sign flip returns y itself. It places idle cycles straight after invalid operations so that a flag or result left over from the previous operation shows up.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NORM = 3'd1,
    CLS_DNRM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } cls_e;

  localparam logic [1:0] RM_DOWN = 2'd3;

  function automatic cls_e cls_fold(input logic [2:0] code);
    cls_e c;
    case (code)
      3'd0:    c = CLS_ZERO;
      3'd2:    c = CLS_DNRM;
      3'd3:    c = CLS_INF;
      3'd4:    c = CLS_QNAN;
      3'd5:    c = CLS_SNAN;
      default: c = CLS_NORM;
    endcase
    return c;
  endfunction

  function automatic logic cls_is_nan(input cls_e c);
    return (c == CLS_QNAN) || (c == CLS_SNAN);
  endfunction

  function automatic logic cls_is_fin(input cls_e c);
    return (c == CLS_ZERO) || (c == CLS_NORM) || (c == CLS_DNRM);
  endfunction

endpackage

// File: rtl/fpsub_nan_pick.sv
module fpsub_nan_pick
  import fpsub_pkg::*;
#(
  parameter int W    = 64,
  parameter int QBIT = 51
) (
  input  cls_e           x_c,
  input  cls_e           y_c,
  input  logic [W-1:0]   x_raw,
  input  logic [W-1:0]   y_raw,
  output logic           hit,
  output logic           inv,
  output logic [W-1:0]   val
);
  localparam logic [W-1:0] QMASK = W'(1) << QBIT;

  always_comb begin
    hit = 1'b1;
    inv = 1'b0;
    val = '0;
    if (x_c == CLS_SNAN) begin
      inv = 1'b1;
      val = x_raw | QMASK;
    end else if (y_c == CLS_SNAN) begin
      inv = 1'b1;
      val = y_raw | QMASK;
    end else if (x_c == CLS_QNAN) begin
      val = x_raw;
    end else if (y_c == CLS_QNAN) begin
      val = y_raw;
    end else begin
      hit = 1'b0;
    end
  end
endmodule

// File: rtl/fpsub_special.sv
module fpsub_special
  import fpsub_pkg::*;
#(
  parameter int W     = 64,
  parameter int EXP_W = 11
) (
  input  cls_e           x_c,
  input  cls_e           y_c,
  input  logic           x_s,
  input  logic           y_s,
  input  logic [W-1:0]   x_raw,
  input  logic [W-1:0]   y_raw,
  input  logic [1:0]     rmode,
  output logic           settle,
  output logic           inv,
  output logic [W-1:0]   val,
  output logic           go,
  output logic           nx,
  output logic           ny
);
  localparam int FRAC_W = W - 1 - EXP_W;
  localparam logic [W-1:0] DNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};

  logic x_inf, y_inf, x_zero, y_zero;
  assign x_inf  = (x_c == CLS_INF);
  assign y_inf  = (y_c == CLS_INF);
  assign x_zero = (x_c == CLS_ZERO);
  assign y_zero = (y_c == CLS_ZERO);

  always_comb begin
    settle = 1'b1;
    inv    = 1'b0;
    val    = '0;
    go     = 1'b0;
    nx     = 1'b0;
    ny     = 1'b0;
    if (x_inf && y_inf) begin
      if (x_s != y_s) begin
        val = x_raw;
      end else begin
        val = DNAN;
        inv = 1'b1;
      end
    end else if (y_inf) begin
      val = {~y_s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (x_inf) begin
      val = x_raw;
    end else if (x_zero && y_zero) begin
      if (x_s != y_s) val = x_raw;
      else            val = {(rmode == RM_DOWN), {(W-1){1'b0}}};
    end else if (y_zero) begin
      val = x_raw;
    end else if (x_zero) begin
      val = y_raw ^ SIGN_BIT;
    end else begin
      settle = 1'b0;
      go     = 1'b1;
      nx     = (x_c == CLS_DNRM);
      ny     = (y_c == CLS_DNRM);
    end
  end
endmodule

// File: rtl/fpsub_resolver.sv
module fpsub_resolver
  import fpsub_pkg::*;
#(
  parameter int W     = 64,
  parameter int EXP_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [2:0]     x_cls,
  input  logic           x_sign,
  input  logic [W-1:0]   x_raw,
  input  logic [2:0]     y_cls,
  input  logic           y_sign,
  input  logic [W-1:0]   y_raw,
  input  logic [1:0]     round_mode,
  output logic           out_valid,
  output logic           out_settled,
  output logic           out_proceed,
  output logic [W-1:0]   out_result,
  output logic           out_invalid,
  output logic           out_norm_x,
  output logic           out_norm_y
);
  localparam int FRAC_W = W - 1 - EXP_W;
  localparam int QBIT   = FRAC_W - 1;

  cls_e xc, yc;
  assign xc = cls_fold(x_cls);
  assign yc = cls_fold(y_cls);

  logic           nan_hit, nan_inv;
  logic [W-1:0]   nan_val;
  logic           sp_settle, sp_inv, sp_go, sp_nx, sp_ny;
  logic [W-1:0]   sp_val;

  fpsub_nan_pick #(.W(W), .QBIT(QBIT)) u_nan (
    .x_c(xc), .y_c(yc), .x_raw(x_raw), .y_raw(y_raw),
    .hit(nan_hit), .inv(nan_inv), .val(nan_val)
  );

  fpsub_special #(.W(W), .EXP_W(EXP_W)) u_spec (
    .x_c(xc), .y_c(yc), .x_s(x_sign), .y_s(y_sign),
    .x_raw(x_raw), .y_raw(y_raw), .rmode(round_mode),
    .settle(sp_settle), .inv(sp_inv), .val(sp_val),
    .go(sp_go), .nx(sp_nx), .ny(sp_ny)
  );

  logic           d_settle, d_inv, d_go, d_nx, d_ny;
  logic [W-1:0]   d_val;

  always_comb begin
    if (nan_hit) begin
      d_settle = 1'b1;
      d_inv    = nan_inv;
      d_val    = nan_val;
      d_go     = 1'b0;
      d_nx     = 1'b0;
      d_ny     = 1'b0;
    end else begin
      d_settle = sp_settle;
      d_inv    = sp_inv;
      d_val    = sp_val;
      d_go     = sp_go;
      d_nx     = sp_nx;
      d_ny     = sp_ny;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid   <= 1'b0;
      out_settled <= 1'b0;
      out_proceed <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_norm_x  <= 1'b0;
      out_norm_y  <= 1'b0;
    end else begin
      out_valid   <= 1'b1;
      out_settled <= d_settle;
      out_proceed <= d_go;
      out_result  <= d_val;
      out_invalid <= d_inv;
      out_norm_x  <= d_nx;
      out_norm_y  <= d_ny;
    end
  end
endmodule

// File: rtl/fpsub_resolver_chk.sv
module fpsub_resolver_chk #(
  parameter int W     = 64,
  parameter int EXP_W = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [2:0]     x_cls,
  input logic [2:0]     y_cls,
  input logic [W-1:0]   x_raw,
  input logic           out_valid,
  input logic           out_settled,
  input logic           out_proceed,
  input logic [W-1:0]   out_result,
  input logic           out_invalid,
  input logic           out_norm_x,
  input logic           out_norm_y
);
  localparam int QBIT = W - 2 - EXP_W;

  logic x_fin_nz, y_fin_nz;
  assign x_fin_nz = (x_cls == 3'd1) || (x_cls == 3'd2) || (x_cls > 3'd5);
  assign y_fin_nz = (y_cls == 3'd1) || (y_cls == 3'd2) || (y_cls > 3'd5);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_settled && !out_proceed && !out_invalid)); // R13
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_settled ^ out_proceed)); // R11
  AST_NORM_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
    (out_norm_x || out_norm_y) |-> out_proceed); // R11
  AST_FINITE_PAIR_GOES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && x_fin_nz && y_fin_nz) |=> (out_proceed && !out_invalid)); // R11
  AST_SNAN_X_WINS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && x_cls == 3'd5) |=> (out_invalid && out_result == ($past(x_raw) | (W'(1) << QBIT)))); // R2
  AST_INVALID_IS_NAN: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (&out_result[W-2 -: EXP_W] && out_result[QBIT])); // R12
endmodule

bind fpsub_resolver fpsub_resolver_chk #(.W(W), .EXP_W(EXP_W)) i_fpsub_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .x_cls(x_cls), .y_cls(y_cls),
  .x_raw(x_raw), .out_valid(out_valid), .out_settled(out_settled),
  .out_proceed(out_proceed), .out_result(out_result), .out_invalid(out_invalid),
  .out_norm_x(out_norm_x), .out_norm_y(out_norm_y)
);

// File: tb/test_fpsub_resolver.sv
`timescale 1ns/1ps
module test_fpsub_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  x_cls = 3'd0, y_cls = 3'd0;
  logic        x_sign = 1'b0, y_sign = 1'b0;
  logic [63:0] x_raw = '0, y_raw = '0;
  logic [1:0]  round_mode = 2'd0;
  logic        out_valid, out_settled, out_proceed, out_invalid, out_norm_x, out_norm_y;
  logic [63:0] out_result;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpsub_resolver i_fpsub_resolver (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x_cls(x_cls), .x_sign(x_sign), .x_raw(x_raw),
    .y_cls(y_cls), .y_sign(y_sign), .y_raw(y_raw),
    .round_mode(round_mode),
    .out_valid(out_valid), .out_settled(out_settled), .out_proceed(out_proceed),
    .out_result(out_result), .out_invalid(out_invalid),
    .out_norm_x(out_norm_x), .out_norm_y(out_norm_y)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  function automatic logic [63:0] mk(input int c, input bit s, input int k);
    logic [50:0] pay;
    pay = 51'h1_2345_6789_ABCD ^ (51'(k) << 9) ^ 51'(k * 7);
    case (c)
      0: return {s, 63'd0};
      1: return {s, 11'(11'h3FF + k[7:0]), 1'b1, pay};
      2: return {s, 11'd0, 1'b0, pay | 51'd1};
      3: return {s, 11'h7FF, 52'd0};
      4: return {s, 11'h7FF, 1'b1, pay};
      default: return {s, 11'h7FF, 1'b0, pay | 51'd1};
    endcase
  endfunction

  task automatic expect_op(input int xc, input int yc, input bit xs, input bit ys,
                           input logic [63:0] xr, input logic [63:0] yr, input int rm,
                           output logic [63:0] r, output bit inv, output bit go,
                           output bit nx, output bit ny, output string tag);
    logic [63:0] q = 64'h0008_0000_0000_0000;
    bit xfin = (xc <= 2), yfin = (yc <= 2);
    r = '0; inv = 0; go = 0; nx = 0; ny = 0;
    if (xc == 5)                  begin r = xr | q; inv = 1; tag = "R2"; end
    else if (yc == 5)             begin r = yr | q; inv = 1; tag = "R3"; end
    else if (xc == 4)             begin r = xr; tag = "R5"; end
    else if (yc == 4)             begin r = yr; tag = "R4"; end
    else if (xc == 3 && yc == 3)  begin
      tag = "R6";
      if (xs != ys) r = xr; else begin r = 64'h7FF8_0000_0000_0000; inv = 1; end
    end
    else if (yc == 3)             begin r = {~ys, 11'h7FF, 52'd0}; tag = "R7"; end
    else if (xc == 3)             begin r = xr; tag = "R8"; end
    else if (xc == 0 && yc == 0)  begin
      tag = "R9";
      if (xs != ys) r = xr; else r = (rm == 3) ? 64'h8000_0000_0000_0000 : 64'd0;
    end
    else if (yc == 0)             begin r = xr; tag = "R10"; end
    else if (xc == 0)             begin r = {~yr[63], yr[62:0]}; tag = "R10"; end
    else if (xfin && yfin)        begin go = 1; nx = (xc == 2); ny = (yc == 2); tag = "R11"; end
  endtask

  task automatic check(input string tag, input logic [69:0] act, input logic [69:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input int xc, input int yc, input bit xs, input bit ys,
                       input int rm, input int k, input bit gap);
    logic [63:0] xr, yr, er;
    bit inv, go, nx, ny;
    string tag;
    xr = mk(xc, xs, k);
    yr = mk(yc, ys, k + 3);
    expect_op(xc, yc, xs, ys, xr, yr, rm, er, inv, go, nx, ny, tag);
    x_cls = 3'(xc); y_cls = 3'(yc); x_sign = xs; y_sign = ys;
    x_raw = xr; y_raw = yr; round_mode = 2'(rm); in_valid = 1'b1;
    @(negedge clk);
    // R1 R12: all outputs one cycle after the operands
    check(tag, {out_valid, out_settled, out_proceed, out_invalid, out_norm_x, out_norm_y, out_result},
               {1'b1, ~go, go, inv, nx, ny, er});
    if (gap) begin
      in_valid = 1'b0;
      x_cls = 3'd5; y_cls = 3'd5;
      @(negedge clk);
      // R13: idle cycle, nothing left over
      check("R13", {out_valid, out_settled, out_proceed, out_invalid, out_norm_x, out_norm_y, out_result},
                   70'd0);
    end
  endtask

  initial begin
    int k = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {out_valid, out_settled, out_proceed, out_invalid, out_norm_x, out_norm_y, out_result}, 70'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R13", {out_valid, out_settled, out_proceed, out_invalid, out_norm_x, out_norm_y, out_result}, 70'd0);
    for (int xc = 0; xc < 6; xc++)
      for (int yc = 0; yc < 6; yc++)
        for (int s = 0; s < 4; s++)
          for (int rm = 0; rm < 4; rm++) begin
            k++;
            apply(xc, yc, s[1], s[0], rm, k, (k % 5) == 0);
          end
    // R1: reserved codes 6 and 7 act as normal
    x_cls = 3'd6; y_cls = 3'd7; x_sign = 0; y_sign = 1;
    x_raw = mk(1, 0, 9); y_raw = mk(1, 1, 4); in_valid = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, out_settled, out_proceed, out_invalid, out_norm_x, out_norm_y, out_result},
                {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 64'd0});
    // R1: reset in mid-stream clears outputs
    rst = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, out_settled, out_proceed, out_invalid, out_norm_x, out_norm_y, out_result}, 70'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule